// File: doc/BRIEF.md
# Luma Horizontal-Edge Deblocking Sequencer

This block walks a list of horizontal luma edges stored in a byte-addressed sample memory and applies the normal-strength (boundary strength below four) luma deblocking filter across each edge. A host fills a descriptor table, sets the edge count and the row stride, and pulses `start`. For each edge the sequencer fetches the descriptor and unpacks the two thresholds and the four signed per-segment clipping strengths. It then works through the sixteen columns of the edge. For each column it reads eight rows of context, runs the filter datapath, and writes back the four rows next to the edge.

Work is skipped as early as possible. An edge whose alpha or beta threshold is zero, and a column whose segment strength is negative, cause no memory traffic at all. A column that fails the sample-difference preconditions is read but never written. The memory port is a plain single-port byte interface with one access per cycle. The descriptor port is a registered lookup by index.

Top module: `dbk_edge_seq`

## Requirements
- R1: After reset, and until `start` is pulsed, `done`, `mem_re`, `mem_we` and `desc_rd` are all low.
- R2: The threshold word carries alpha in bits 7:0 and beta in bits 15:8. An edge with alpha equal to zero or beta equal to zero produces no memory read and no memory write.
- R3: The strength word carries four 8-bit two's-complement values, segment s in bits 8s+7:8s. Column c uses segment c>>2. A column whose value is negative produces no memory access.
- R4: For each processed column, exactly eight reads are issued, at addresses offset + c + k*stride for k = -4..+3. All address arithmetic is modulo 2^ADDR_W.
- R5: A column is filtered only when |p0-q0| < alpha, |p1-p0| < beta and |q1-q0| < beta. Otherwise it gets no memory write.
- R6: For a filtered column, tc = tc0 + (|p2-p0| < beta) + (|q2-q0| < beta). delta = clip3(-tc, tc, (4(q0-p0) + (p1-q1) + 4) >> 3). p0 and q0 become p0+delta and q0-delta, each clipped to 0..255.
- R7: For a filtered column, p1 is replaced by p1 + clip3(-tc0, tc0, (p2 + ((p0+q0+1)>>1) - 2p1) >> 1) only when |p2-p0| < beta. q1 is updated symmetrically only when |q2-q0| < beta. Otherwise each keeps its value.
- R8: A filtered column gets exactly four writes, at rows -2, -1, 0 and +1. No other row is ever written.
- R9: Edges are processed in ascending index order. No descriptor with index at or beyond `edge_count` is read. An edge count of zero finishes with no access.
- R10: `done` is high for exactly one cycle after the last access of a job, and no access follows it.
- R11: The memory and descriptor ports take read data the cycle after the request. There is at most one memory access per cycle, and none in a cycle that reads a descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the edge list |
| done | output | 1 | One-cycle completion pulse |
| edge_count | input | IDX_W | Number of descriptors to process |
| stride | input | STRIDE_W | Byte distance between rows |
| desc_rd | output | 1 | Descriptor read request |
| desc_idx | output | IDX_W | Descriptor index being read |
| desc_offset | input | ADDR_W | Byte address of row 0, column 0 of the lower block (valid the cycle after desc_rd) |
| desc_thresh | input | 16 | Alpha in bits 7:0, beta in bits 15:8 |
| desc_tc0 | input | 32 | Four signed segment strengths |
| mem_re | output | 1 | Sample memory read request |
| mem_we | output | 1 | Sample memory write request |
| mem_addr | output | ADDR_W | Sample memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |

## Verification
The bench builds the block with ADDR_W = 11, STRIDE_W = 8 and IDX_W = 4. A 2048-byte behavioural memory can therefore cover the whole address space, and an edge near address zero makes its upper context rows wrap to the top of memory. The 16-entry descriptor table is larger than the edge counts used, so a live but out-of-range descriptor sits right after the last one processed. A stride of 32 lets two edges overlap by a few rows, which makes the processing order visible in the final memory contents. A flat two-level image puts the alpha comparison exactly on its boundary, and full-range noise drives most columns into the precondition reject path.

// File: rtl/dbk_pkg.sv
package dbk_pkg;

    localparam int EDGE_COLS  = 16;
    localparam int SEG_COLS   = 4;
    localparam int NUM_SEGS   = EDGE_COLS / SEG_COLS;
    localparam int CTX_ROWS   = 8;
    localparam int ROWS_ABOVE = CTX_ROWS / 2;
    localparam int WIN_FIRST  = 1;
    localparam int WIN_ROWS   = CTX_ROWS - 2;
    localparam int WB_FIRST   = 2;
    localparam int WB_ROWS    = 4;
    localparam int COL_W      = $clog2(EDGE_COLS);
    localparam int ROW_W      = $clog2(CTX_ROWS);
    localparam int SEG_W      = $clog2(NUM_SEGS);
    localparam int WB_W       = $clog2(WB_ROWS);

    typedef logic [7:0] pix_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DREQ,
        ST_DLAT,
        ST_ECHK,
        ST_CCHK,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_NCOL,
        ST_NEDGE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [15:0] thresh;
        logic [31:0] strength;
    } edge_param_t;

    function automatic int abs_diff(input int a, input int b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic int clip3(input int lo, input int hi, input int v);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/dbk_param_unpack.sv
module dbk_param_unpack
    import dbk_pkg::*;
(
    input  edge_param_t       prm,
    input  logic [SEG_W-1:0]  seg,
    output pix_t              alpha,
    output pix_t              beta,
    output logic              edge_off,
    output pix_t              seg_tc0,
    output logic              seg_skip
);
    pix_t [NUM_SEGS-1:0] seg_val;
    logic [NUM_SEGS-1:0] seg_neg;

    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
        assign seg_val[s] = prm.strength[8*s +: 8];
        assign seg_neg[s] = prm.strength[8*s + 7];
    end

    assign alpha    = prm.thresh[7:0];
    assign beta     = prm.thresh[15:8];
    assign edge_off = (alpha == 8'd0) || (beta == 8'd0);
    assign seg_tc0  = seg_val[seg];
    assign seg_skip = seg_neg[seg];

endmodule

// File: rtl/dbk_addr_gen.sv
module dbk_addr_gen
    import dbk_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int STRIDE_W = 12
) (
    input  logic [ADDR_W-1:0]   base,
    input  logic [COL_W-1:0]    col,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [ROW_W-1:0]    row,
    output logic [ADDR_W-1:0]   addr
);
    logic [ADDR_W-1:0] col_base;
    logic [ADDR_W-1:0] row_term;
    logic [ADDR_W-1:0] above;

    always_comb begin
        col_base = base + ADDR_W'(col);
        row_term = ADDR_W'(stride) * ADDR_W'(row);
        above    = ADDR_W'(stride) * ADDR_W'(ROWS_ABOVE);
        addr     = col_base + row_term - above;
    end

endmodule

// File: rtl/dbk_filter_core.sv
module dbk_filter_core
    import dbk_pkg::*;
(
    input  pix_t [WIN_ROWS-1:0] win,
    input  pix_t                alpha,
    input  pix_t                beta,
    input  pix_t                tc0,
    output logic                pass,
    output pix_t [WB_ROWS-1:0]  wb
);
    always_comb begin
        int p2, p1, p0, q0, q1, q2;
        int t0, tc, dlt, avg, dp1, dq1;
        logic ap_ok, aq_ok;
        p2 = int'(win[0]);
        p1 = int'(win[1]);
        p0 = int'(win[2]);
        q0 = int'(win[3]);
        q1 = int'(win[4]);
        q2 = int'(win[5]);
        t0 = int'(tc0);
        pass  = (abs_diff(p0, q0) < int'(alpha)) &&
                (abs_diff(p1, p0) < int'(beta))  &&
                (abs_diff(q1, q0) < int'(beta));
        ap_ok = abs_diff(p2, p0) < int'(beta);
        aq_ok = abs_diff(q2, q0) < int'(beta);
        tc    = t0 + (ap_ok ? 1 : 0) + (aq_ok ? 1 : 0);
        dlt   = clip3(-tc, tc, ((q0 - p0) * 4 + (p1 - q1) + 4) >>> 3);
        avg   = (p0 + q0 + 1) >>> 1;
        dp1   = clip3(-t0, t0, (p2 + avg - 2 * p1) >>> 1);
        dq1   = clip3(-t0, t0, (q2 + avg - 2 * q1) >>> 1);
        wb[0] = ap_ok ? pix_t'(p1 + dp1) : win[1];
        wb[1] = pix_t'(clip3(0, 255, p0 + dlt));
        wb[2] = pix_t'(clip3(0, 255, q0 - dlt));
        wb[3] = aq_ok ? pix_t'(q1 + dq1) : win[4];
    end

endmodule

// File: rtl/dbk_edge_seq.sv
module dbk_edge_seq
    import dbk_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int STRIDE_W = 12,
    parameter int IDX_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                done,
    input  logic [IDX_W-1:0]    edge_count,
    input  logic [STRIDE_W-1:0] stride,
    output logic                desc_rd,
    output logic [IDX_W-1:0]    desc_idx,
    input  logic [ADDR_W-1:0]   desc_offset,
    input  logic [15:0]         desc_thresh,
    input  logic [31:0]         desc_tc0,
    output logic                mem_re,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(EDGE_COLS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(CTX_ROWS - 1);
    localparam logic [WB_W-1:0]  LAST_WB  = WB_W'(WB_ROWS - 1);

    seq_state_e          state_q;
    logic [IDX_W-1:0]    edge_q;
    logic [COL_W-1:0]    col_q;
    logic [ROW_W-1:0]    row_q;
    logic [WB_W-1:0]     wb_q;
    logic [ADDR_W-1:0]   off_q;
    edge_param_t         prm_q;
    pix_t [WIN_ROWS-1:0] win_q;
    pix_t [WB_ROWS-1:0]  res_q;
    logic                rd_pend_q;
    logic [ROW_W-1:0]    rd_row_q;

    pix_t               alpha, beta, seg_tc0;
    logic               edge_off, seg_skip;
    logic               pass;
    pix_t [WB_ROWS-1:0] wb_vals;
    logic [ROW_W-1:0]   row_sel;
    logic               last_edge;

    dbk_param_unpack u_unpack (
        .prm      (prm_q),
        .seg      (col_q[COL_W-1 -: SEG_W]),
        .alpha    (alpha),
        .beta     (beta),
        .edge_off (edge_off),
        .seg_tc0  (seg_tc0),
        .seg_skip (seg_skip)
    );

    dbk_addr_gen #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W)
    ) u_addr (
        .base   (off_q),
        .col    (col_q),
        .stride (stride),
        .row    (row_sel),
        .addr   (mem_addr)
    );

    dbk_filter_core u_core (
        .win   (win_q),
        .alpha (alpha),
        .beta  (beta),
        .tc0   (seg_tc0),
        .pass  (pass),
        .wb    (wb_vals)
    );

    assign row_sel   = (state_q == ST_WRITE) ? (ROW_W'(WB_FIRST) + ROW_W'(wb_q)) : row_q;
    assign last_edge = ({1'b0, edge_q} + (IDX_W+1)'(1)) >= {1'b0, edge_count};

    assign desc_rd   = (state_q == ST_DREQ);
    assign desc_idx  = edge_q;
    assign mem_re    = (state_q == ST_READ);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_wdata = res_q[wb_q];
    assign done      = (state_q == ST_DONE);

    // Read return: data for the row requested last cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend_q <= 1'b0;
            rd_row_q  <= '0;
            win_q     <= '0;
        end else begin
            rd_pend_q <= mem_re;
            rd_row_q  <= row_q;
            if (rd_pend_q && rd_row_q >= ROW_W'(WIN_FIRST) &&
                rd_row_q < ROW_W'(WIN_FIRST + WIN_ROWS)) begin
                win_q[rd_row_q - ROW_W'(WIN_FIRST)] <= mem_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            edge_q  <= '0;
            col_q   <= '0;
            row_q   <= '0;
            wb_q    <= '0;
            off_q   <= '0;
            prm_q   <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        edge_q  <= '0;
                        state_q <= (edge_count == '0) ? ST_DONE : ST_DREQ;
                    end
                end
                ST_DREQ: state_q <= ST_DLAT;
                ST_DLAT: begin
                    off_q        <= desc_offset;
                    prm_q.thresh   <= desc_thresh;
                    prm_q.strength <= desc_tc0;
                    state_q      <= ST_ECHK;
                end
                ST_ECHK: begin
                    col_q   <= '0;
                    state_q <= edge_off ? ST_NEDGE : ST_CCHK;
                end
                ST_CCHK: begin
                    row_q   <= '0;
                    state_q <= seg_skip ? ST_NCOL : ST_READ;
                end
                ST_READ: begin
                    row_q <= row_q + ROW_W'(1);
                    if (row_q == LAST_ROW) state_q <= ST_CALC;
                end
                ST_CALC: begin
                    res_q   <= wb_vals;
                    wb_q    <= '0;
                    state_q <= pass ? ST_WRITE : ST_NCOL;
                end
                ST_WRITE: begin
                    wb_q <= wb_q + WB_W'(1);
                    if (wb_q == LAST_WB) state_q <= ST_NCOL;
                end
                ST_NCOL: begin
                    if (col_q == LAST_COL) begin
                        state_q <= ST_NEDGE;
                    end else begin
                        col_q   <= col_q + COL_W'(1);
                        state_q <= ST_CCHK;
                    end
                end
                ST_NEDGE: begin
                    if (last_edge) begin
                        state_q <= ST_DONE;
                    end else begin
                        edge_q  <= edge_q + IDX_W'(1);
                        state_q <= ST_DREQ;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dbk_edge_seq_chk.sv
module dbk_edge_seq_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             desc_rd,
    input logic [IDX_W-1:0] desc_idx,
    input logic [IDX_W-1:0] edge_count,
    input logic             mem_re,
    input logic             mem_we
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!done && !mem_re && !mem_we && !desc_rd));

    assert_one_access_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_re, mem_we}));

    assert_desc_alone_R11: assert property (@(posedge clk) disable iff (rst)
        desc_rd |-> (!mem_re && !mem_we));

    assert_desc_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        desc_rd |-> (desc_idx < edge_count));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!mem_re && !mem_we && !desc_rd));

endmodule

bind dbk_edge_seq dbk_edge_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .desc_rd    (desc_rd),
    .desc_idx   (desc_idx),
    .edge_count (edge_count),
    .mem_re     (mem_re),
    .mem_we     (mem_we)
);

// File: tb/dbk_edge_seq_tb.sv
module dbk_edge_seq_tb;
    localparam int ADDR_W   = 11;
    localparam int STRIDE_W = 8;
    localparam int IDX_W    = 4;
    localparam int MEMN     = 1 << ADDR_W;
    localparam int NDESC    = 1 << IDX_W;
    localparam int STRIDE   = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic done;
    logic [IDX_W-1:0] edge_count = '0;
    logic [STRIDE_W-1:0] stride = STRIDE_W'(STRIDE);
    logic desc_rd;
    logic [IDX_W-1:0] desc_idx;
    logic [ADDR_W-1:0] desc_offset;
    logic [15:0] desc_thresh;
    logic [31:0] desc_tc0;
    logic mem_re, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    logic [7:0] mem [MEMN];
    logic [7:0] ref_mem [MEMN];
    logic [ADDR_W-1:0] d_off [NDESC];
    logic [15:0] d_thr [NDESC];
    logic [31:0] d_tc [NDESC];

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0, wr_cnt = 0, dr_cnt = 0, both_cnt = 0, bad_desc = 0;

    always #10 clk = ~clk;

    dbk_edge_seq #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .edge_count(edge_count), .stride(stride),
        .desc_rd(desc_rd), .desc_idx(desc_idx), .desc_offset(desc_offset),
        .desc_thresh(desc_thresh), .desc_tc0(desc_tc0),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (desc_rd) begin
            desc_offset <= d_off[desc_idx];
            desc_thresh <= d_thr[desc_idx];
            desc_tc0    <= d_tc[desc_idx];
        end
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (mem_re) rd_cnt <= rd_cnt + 1;
            if (mem_we) wr_cnt <= wr_cnt + 1;
            if (desc_rd) dr_cnt <= dr_cnt + 1;
            if (mem_re && mem_we) both_cnt <= both_cnt + 1;
            if (desc_rd && (desc_idx >= edge_count)) bad_desc <= bad_desc + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int clipv(input int lo, input int hi, input int v);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic fill_noise(input int seed, input int base, input int amp);
        int s = seed;
        for (int a = 0; a < MEMN; a++) begin
            int v;
            s = s * 1103515245 + 12345;
            v = clipv(0, 255, base + (((s >>> 16) & 32767) % amp));
            mem[a] = 8'(v);
            ref_mem[a] = 8'(v);
        end
    endtask

    task automatic set_byte(input int a, input int v);
        mem[a & (MEMN - 1)] = 8'(v);
        ref_mem[a & (MEMN - 1)] = 8'(v);
    endtask

    // Independent model of R2..R9: per-edge, per-column processing in index order.
    task automatic ref_run(input int n, output int er, output int ew);
        er = 0;
        ew = 0;
        for (int e = 0; e < n; e++) begin
            int al, be;
            al = int'(d_thr[e][7:0]);
            be = int'(d_thr[e][15:8]);
            if (al == 0 || be == 0) continue;
            for (int c = 0; c < 16; c++) begin
                int t0, px[8], ad[8], tc, dl, av, np1, nq1;
                bit apk, aqk;
                t0 = int'($signed(d_tc[e][8*(c/4) +: 8]));
                if (t0 < 0) continue;
                er += 8;
                for (int k = 0; k < 8; k++) begin
                    ad[k] = (int'(d_off[e]) + c + (k - 4) * STRIDE) & (MEMN - 1);
                    px[k] = int'(ref_mem[ad[k]]);
                end
                if (!(iabs(px[3] - px[4]) < al && iabs(px[2] - px[3]) < be &&
                      iabs(px[5] - px[4]) < be)) continue;
                ew += 4;
                apk = iabs(px[1] - px[3]) < be;
                aqk = iabs(px[6] - px[4]) < be;
                tc = t0 + int'(apk) + int'(aqk);
                dl = clipv(-tc, tc, ((px[4] - px[3]) * 4 + (px[2] - px[5]) + 4) >>> 3);
                av = (px[3] + px[4] + 1) >>> 1;
                np1 = apk ? px[2] + clipv(-t0, t0, (px[1] + av - 2 * px[2]) >>> 1) : px[2];
                nq1 = aqk ? px[5] + clipv(-t0, t0, (px[6] + av - 2 * px[5]) >>> 1) : px[5];
                ref_mem[ad[2]] = 8'(np1);
                ref_mem[ad[3]] = 8'(clipv(0, 255, px[3] + dl));
                ref_mem[ad[4]] = 8'(clipv(0, 255, px[4] - dl));
                ref_mem[ad[5]] = 8'(nq1);
            end
        end
    endtask

    task automatic run_job(input int n, output int rd, output int wr, output int dr);
        int r0, w0, d0, guard;
        r0 = rd_cnt; w0 = wr_cnt; d0 = dr_cnt;
        @(negedge clk);
        edge_count = IDX_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R10 done seen", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", int'(done), 0);
        rd = rd_cnt - r0; wr = wr_cnt - w0; dr = dr_cnt - d0;
    endtask

    task automatic compare_mem(input string req);
        int bad = 0, first = -1;
        for (int a = 0; a < MEMN; a++) begin
            if (mem[a] !== ref_mem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (bad != 0)
            $display("FAIL %s byte %0d actual=%0d expected=%0d", req, first, mem[first], ref_mem[first]);
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(done == 1'b0, "R1 done low", int'(done), 0);
        check(!mem_re && !mem_we, "R1 no memory access", int'({mem_re, mem_we}), 0);
        check(desc_rd == 1'b0, "R1 no descriptor read", int'(desc_rd), 0);
    endtask

    task automatic t_mixed;
        int er, ew, rd, wr, dr;
        fill_noise(7, 112, 16);
        d_off[0] = ADDR_W'(6 * STRIDE + 3);
        d_thr[0] = {8'd8, 8'd24};
        d_tc[0]  = {8'd2, 8'd3, 8'd0, 8'd1};
        ref_run(1, er, ew);
        run_job(1, rd, wr, dr);
        check(rd == er, "R4 eight reads per column", rd, er);
        check(wr == ew, "R8 four writes per passing column", wr, ew);
        compare_mem("R6 R7 filtered samples");
    endtask

    task automatic t_edge_skip;
        int er, ew, rd, wr, dr;
        fill_noise(11, 100, 12);
        d_off[0] = ADDR_W'(10 * STRIDE);      d_thr[0] = {8'd9, 8'd0};  d_tc[0] = 32'h04040404;
        d_off[1] = ADDR_W'(20 * STRIDE + 8);  d_thr[1] = {8'd0, 8'd30}; d_tc[1] = 32'h04040404;
        d_off[2] = ADDR_W'(40 * STRIDE + 16); d_thr[2] = {8'd9, 8'd30}; d_tc[2] = 32'h01020304;
        ref_run(3, er, ew);
        run_job(3, rd, wr, dr);
        check(rd == 128, "R2 zero alpha/beta edges read nothing", rd, 128);
        check(wr == ew, "R2 writes only from live edge", wr, ew);
        compare_mem("R2 memory after skipped edges");
    endtask

    task automatic t_tc0_neg;
        int er, ew, rd, wr, dr;
        fill_noise(23, 90, 10);
        d_off[0] = ADDR_W'(30 * STRIDE + 5);
        d_thr[0] = {8'd12, 8'd30};
        d_tc[0]  = {8'h80, 8'h05, 8'hFF, 8'h02};
        ref_run(1, er, ew);
        run_job(1, rd, wr, dr);
        check(rd == 64, "R3 negative segments read nothing", rd, 64);
        check(wr == ew, "R3 write count", wr, ew);
        compare_mem("R3 segment unpack");
    endtask

    task automatic t_boundary(input int alpha, input int exp_wr);
        int er, ew, rd, wr, dr;
        fill_noise(1, 100, 1);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 16; c++) set_byte(50 * STRIDE + r * STRIDE + c, 110);
        d_off[0] = ADDR_W'(50 * STRIDE);
        d_thr[0] = {8'd8, 8'(alpha)};
        d_tc[0]  = 32'h01010101;
        ref_run(1, er, ew);
        run_job(1, rd, wr, dr);
        check(wr == exp_wr, "R5 alpha boundary write count", wr, exp_wr);
        compare_mem("R5 alpha boundary samples");
    endtask

    task automatic t_noisy;
        int er, ew, rd, wr, dr;
        fill_noise(99, 0, 256);
        d_off[0] = ADDR_W'(12 * STRIDE + 2);
        d_thr[0] = {8'd20, 8'd60};
        d_tc[0]  = 32'h03030303;
        ref_run(1, er, ew);
        run_job(1, rd, wr, dr);
        check(wr == ew, "R5 precondition reject count", wr, ew);
        compare_mem("R5 rejected columns untouched");
    endtask

    task automatic t_order;
        int er, ew, rd, wr, dr, bd0;
        fill_noise(5, 120, 14);
        d_off[0] = ADDR_W'(20 * STRIDE);     d_thr[0] = {8'd10, 8'd30}; d_tc[0] = 32'h02020202;
        d_off[1] = ADDR_W'(22 * STRIDE);     d_thr[1] = {8'd10, 8'd30}; d_tc[1] = 32'h04030201;
        d_off[2] = ADDR_W'(21 * STRIDE);     d_thr[2] = {8'd10, 8'd30}; d_tc[2] = 32'h05050505;
        bd0 = bad_desc;
        ref_run(2, er, ew);
        run_job(2, rd, wr, dr);
        check(dr == 2, "R9 descriptors read", dr, 2);
        check(bad_desc == bd0, "R9 no out-of-range descriptor", bad_desc - bd0, 0);
        compare_mem("R9 overlapping edges in index order");
    endtask

    task automatic t_zero;
        int rd, wr, dr;
        run_job(0, rd, wr, dr);
        check(rd + wr + dr == 0, "R9 zero count makes no access", rd + wr + dr, 0);
    endtask

    task automatic t_wrap;
        int er, ew, rd, wr, dr;
        fill_noise(77, 60, 12);
        d_off[0] = ADDR_W'(STRIDE + 6);
        d_thr[0] = {8'd7, 8'd18};
        d_tc[0]  = 32'h00020103;
        ref_run(1, er, ew);
        run_job(1, rd, wr, dr);
        check(rd == 128, "R4 wrapped read count", rd, 128);
        compare_mem("R4 address wrap");
    endtask

    initial begin
        for (int i = 0; i < NDESC; i++) begin
            d_off[i] = '0; d_thr[i] = 16'h0101; d_tc[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mixed();
        t_edge_skip();
        t_tc0_neg();
        t_boundary(10, 0);
        t_boundary(11, 64);
        t_noisy();
        t_order();
        t_zero();
        t_wrap();
        check(both_cnt == 0, "R11 single access per cycle", both_cnt, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule